// File: doc/BRIEF.md
# Address Region Router with Fixed-Priority Arbitration

This block sits between three bus requesters (core data, instruction and vector fetch, debug) and four downstream ports: a code-instruction port, a code-data port, a system port and an external private-peripheral port. Each cycle it decodes every pending 32-bit address into a region code. It picks one winner per port by fixed priority and answers each requester with either a grant pulse or an error pulse.

A port that has started an access stays occupied until its downstream side signals ready. A lower-priority requester therefore waits until the access ahead of it has finished. The external peripheral window is protected by access rules on privilege, access size, alignment and requester origin. A broken rule produces an error and nothing is forwarded. The block also tells each port whether to byte-swap data for big-endian operation. The peripheral window always stays little-endian.

Requesters hold their request and its attributes stable until they see a grant or an error. The requester index is 0 for data, 1 for fetch and 2 for debug. The port index is 0 for code-instruction, 1 for code-data, 2 for system and 3 for external peripheral.

Top module: `addr_route_arb`

## Requirements
- R1: A fetch to 0x00000000–0x1FFFFFFC reports region code 1 (code-instruction). A data or debug access to 0x00000000–0x1FFFFFFF reports region code 2 (code-data). A fetch to 0x1FFFFFFD–0x1FFFFFFF reports region code 0.
- R2: Any access to 0x20000000–0xDFFFFFFF or to 0xE0100000–0xFFFFFFFF reports region code 3 (system).
- R3: Any access to 0xE0040000–0xE00FFFFF reports region code 4 (external peripheral). Every other address reports region code 0, and a request whose region code is 0 gets an error pulse in the same cycle.
- R4: When several routable requests want the same free port in one cycle, the lowest requester index is granted (data, then fetch, then debug). The grant is a one-cycle pulse in the cycle the port accepts.
- R5: A port that starts an access in a cycle (prt_start_o high, prt_mst_o naming the requester) accepts nothing in the next cycle. It stays closed until a cycle after it has seen port_rdy_i high at a clock edge.
- R6: A request to the external peripheral window gets an error and is never forwarded if any of these hold: it is unprivileged (priv_i=0), its size code is not 2 (size code 0 = byte, 1 = halfword, 2 = word), its address bits [1:0] are not 0, or it is a data request flagged as coming from another processor (dat_remote_i=1).
- R7: A fetch to the external peripheral window gets an error and is never forwarded.
- R8: Each of ports 0 to 2 has a byte-swap flag equal to be_mode_i. Port 3 has a byte-swap flag of 0.
- R9: A requester never receives a grant and an error in the same cycle.
- R10: Out of reset every port is free, so the first routable request after reset is granted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 3 | Request valid per requester |
| addr_i | input | 3x32 | Address per requester |
| size_i | input | 3x2 | Size code per requester (0 byte, 1 half, 2 word) |
| priv_i | input | 3 | Privileged flag per requester |
| dat_remote_i | input | 1 | Data request originates from another processor |
| be_mode_i | input | 1 | Processor data endianness is big-endian |
| port_rdy_i | input | 4 | Downstream port has completed its current access |
| gnt_o | output | 3 | Grant pulse per requester |
| err_o | output | 3 | Error pulse per requester |
| region_o | output | 3x3 | Decoded region code per requester |
| prt_start_o | output | 4 | Access accepted on the port this cycle |
| prt_mst_o | output | 4x2 | Requester index of the accepted access |
| prt_bigend_o | output | 4 | Byte-swap flag per port |

## Verification
Every cycle, assertions check the following:
- A grant and an error never reach the same requester together.
- Each port starts at most one access, and never one whose requester has a lower-index rival waiting.
- A port stays shut after a start until ready is seen.
- Fetches into the peripheral window always error.
- Anything forwarded to that window is a privileged word access.

Other behaviour needs the bench's scenarios. These include exact region codes at the range boundaries, and the full order of service when three requesters meet on a port. They also include the wait a debug access serves behind a core access to the peripheral window, and the byte-swap flags following the endianness input.

// File: rtl/addr_route_pkg.sv
// Package: shared constants, region encoding and address map for the router.
// Assumes 32-bit addresses and three requesters with fixed indices.
package addr_route_pkg;
    localparam int NREQ   = 3;
    localparam int NPORT  = 4;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 2;
    localparam int RGN_W  = 3;
    localparam int MST_W  = $clog2(NREQ);

    localparam int REQ_DATA  = 0;
    localparam int REQ_FETCH = 1;
    localparam int REQ_DBG   = 2;

    localparam int PORT_XPPB = 3;

    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

    localparam logic [ADDR_W-1:0] CODE_END   = 32'h1FFF_FFFF;
    localparam logic [ADDR_W-1:0] FETCH_END  = 32'h1FFF_FFFC;
    localparam logic [ADDR_W-1:0] SYS_LO_BEG = 32'h2000_0000;
    localparam logic [ADDR_W-1:0] SYS_LO_END = 32'hDFFF_FFFF;
    localparam logic [ADDR_W-1:0] XPPB_BEG   = 32'hE004_0000;
    localparam logic [ADDR_W-1:0] XPPB_END   = 32'hE00F_FFFF;
    localparam logic [ADDR_W-1:0] SYS_HI_BEG = 32'hE010_0000;

    typedef enum logic [RGN_W-1:0] {
        RG_NONE   = 3'd0,
        RG_CODE_I = 3'd1,
        RG_CODE_D = 3'd2,
        RG_SYS    = 3'd3,
        RG_XPPB   = 3'd4
    } region_e;
endpackage

// File: rtl/addr_route_decode.sv
// Module: per-requester address decoder and peripheral-window rule checker.
// Purely combinational. Assumes attributes are stable while a request is held.
// IS_FETCH marks the fetch requester; USE_REMOTE enables the foreign-origin check.
module addr_route_decode
    import addr_route_pkg::*;
#(
    parameter bit IS_FETCH   = 1'b0,
    parameter bit USE_REMOTE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              priv_i,
    input  logic              remote_i,
    output region_e           region_o,
    output logic              viol_o
);
    logic in_code;
    logic in_sys;
    logic in_xppb;
    logic xppb_bad;

    // Range compares for each address window.
    always_comb begin
        in_code = (addr_i <= CODE_END);
        in_sys  = ((addr_i >= SYS_LO_BEG) && (addr_i <= SYS_LO_END)) || (addr_i >= SYS_HI_BEG);
        in_xppb = (addr_i >= XPPB_BEG) && (addr_i <= XPPB_END);
    end

    // Region selection; fetches past the last aligned code word are unroutable.
    always_comb begin
        if (in_code) begin
            if (IS_FETCH) region_o = (addr_i <= FETCH_END) ? RG_CODE_I : RG_NONE;
            else          region_o = RG_CODE_D;
        end else if (in_sys) begin
            region_o = RG_SYS;
        end else if (in_xppb) begin
            region_o = RG_XPPB;
        end else begin
            region_o = RG_NONE;
        end
    end

    // Peripheral-window rules: privileged, word size, aligned, local, not a fetch.
    always_comb begin
        xppb_bad = !priv_i || (size_i != SZ_WORD) || (addr_i[1:0] != 2'b00)
                 || (USE_REMOTE && remote_i) || IS_FETCH;
        viol_o   = (region_o == RG_NONE) || ((region_o == RG_XPPB) && xppb_bad);
    end
endmodule

// File: rtl/addr_route_port_arb.sv
// Module: fixed-priority arbiter and occupancy tracker for one downstream port.
// Lowest candidate index wins. The port is closed from the cycle after a start
// until ready is sampled at a clock edge. Assumes candidates hold until granted.
module addr_route_port_arb #(
    parameter int NR = 3,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NR-1:0] cand_i,
    input  logic          rdy_i,
    output logic [NR-1:0] gnt_o,
    output logic          start_o,
    output logic [MW-1:0] mst_o
);
    logic busy_q;
    logic found;

    // Pick the lowest-index candidate while the port is free.
    always_comb begin
        gnt_o = '0;
        mst_o = '0;
        found = 1'b0;
        if (!busy_q) begin
            for (int i = 0; i < NR; i++) begin
                if (cand_i[i] && !found) begin
                    gnt_o[i] = 1'b1;
                    mst_o    = MW'(i);
                    found    = 1'b1;
                end
            end
        end
        start_o = found;
    end

    // Occupancy: set on a start, cleared when the downstream side is ready.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_q <= 1'b0;
        else if (start_o) busy_q <= 1'b1;
        else if (rdy_i)   busy_q <= 1'b0;
    end

    // R4: at most one grant, and no lower-index candidate is passed over.
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ((cand_i & (gnt_o - NR'(1))) == '0));
    // R5: no back-to-back starts, and the port stays shut until ready.
    a_r5_no_back2back: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r5_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !rdy_i) ##1 !rdy_i |=> !start_o);
endmodule

// File: rtl/addr_route_arb.sv
// Module: top of the router. Decodes three requesters, checks the peripheral
// window rules, arbitrates each port with fixed priority and drives the
// per-port byte-swap flags. Requesters hold their request until grant or error.
module addr_route_arb
    import addr_route_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREQ-1:0]              req_i,
    input  logic [NREQ-1:0][ADDR_W-1:0]  addr_i,
    input  logic [NREQ-1:0][SIZE_W-1:0]  size_i,
    input  logic [NREQ-1:0]              priv_i,
    input  logic                         dat_remote_i,
    input  logic                         be_mode_i,
    input  logic [NPORT-1:0]             port_rdy_i,
    output logic [NREQ-1:0]              gnt_o,
    output logic [NREQ-1:0]              err_o,
    output logic [NREQ-1:0][RGN_W-1:0]   region_o,
    output logic [NPORT-1:0]             prt_start_o,
    output logic [NPORT-1:0][MST_W-1:0]  prt_mst_o,
    output logic [NPORT-1:0]             prt_bigend_o
);
    region_e                       rg [NREQ];
    logic [NREQ-1:0]               viol;
    logic [NPORT-1:0][NREQ-1:0]    cand;
    logic [NPORT-1:0][NREQ-1:0]    gnt_pr;

    for (genvar r = 0; r < NREQ; r++) begin : g_req
        addr_route_decode #(
            .IS_FETCH  (1'(r == REQ_FETCH)),
            .USE_REMOTE(1'(r == REQ_DATA))
        ) u_dec (
            .addr_i  (addr_i[r]),
            .size_i  (size_i[r]),
            .priv_i  (priv_i[r]),
            .remote_i(dat_remote_i),
            .region_o(rg[r]),
            .viol_o  (viol[r])
        );

        // Region reporting and immediate error response.
        always_comb begin
            region_o[r] = rg[r];
            err_o[r]    = req_i[r] && viol[r];
        end

        // R9: grant and error are exclusive per requester.
        a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(gnt_o[r] && err_o[r]));
        // R6: anything forwarded to the peripheral window is a privileged word access.
        a_r6_fwd_rules: assert property (@(posedge clk) disable iff (!rst_n)
            (prt_start_o[PORT_XPPB] && (prt_mst_o[PORT_XPPB] == MST_W'(r)))
            |-> (size_i[r] == SZ_WORD) && priv_i[r] && (addr_i[r][1:0] == 2'b00));
    end

    // Build each port's candidate set from routable requests.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            for (int r = 0; r < NREQ; r++) begin
                cand[p][r] = req_i[r] && !viol[r] && (rg[r] == region_e'(RGN_W'(p + 1)));
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        addr_route_port_arb #(
            .NR(NREQ),
            .MW(MST_W)
        ) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (cand[p]),
            .rdy_i  (port_rdy_i[p]),
            .gnt_o  (gnt_pr[p]),
            .start_o(prt_start_o[p]),
            .mst_o  (prt_mst_o[p])
        );

        if (p == PORT_XPPB) begin : g_le
            // Peripheral window is little-endian whatever the core setting.
            assign prt_bigend_o[p] = 1'b0;
        end else begin : g_be
            // Other ports follow the processor endianness.
            assign prt_bigend_o[p] = be_mode_i;
        end
    end

    // Merge per-port grants into per-requester grants.
    always_comb begin
        gnt_o = '0;
        for (int p = 0; p < NPORT; p++) gnt_o = gnt_o | gnt_pr[p];
    end

    // R7: a fetch into the peripheral window is always refused.
    a_r7_fetch_xppb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[REQ_FETCH] && (addr_i[REQ_FETCH] >= XPPB_BEG) && (addr_i[REQ_FETCH] <= XPPB_END))
        |-> err_o[REQ_FETCH]);
    // R6: a refused data request is never forwarded to the peripheral port.
    a_r6_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        err_o[REQ_DATA] |-> !(prt_start_o[PORT_XPPB] && (prt_mst_o[PORT_XPPB] == MST_W'(REQ_DATA))));
endmodule

// File: tb/addr_route_arb_tb_top.sv
`timescale 1ns/1ps
module addr_route_arb_tb_top;
    typedef struct {
        logic [31:0] a;
        logic [1:0]  sz;
        logic        pv;
        logic        rm;
    } txn_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       req = '0;
    logic [2:0][31:0] addr = '0;
    logic [2:0][1:0]  size = '0;
    logic [2:0]       priv = '0;
    logic             remote = 1'b0;
    logic             be_mode = 1'b0;
    logic [3:0]       rdy = '0;
    logic [2:0]       gnt, err;
    logic [2:0][2:0]  region;
    logic [3:0]       pstart;
    logic [3:0][1:0]  pmst;
    logic [3:0]       pbig;

    int  nchk = 0;
    int  nfail = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  busy_m [4];
    bit  act [3];
    txn_t cur [3];
    txn_t q0[$], q1[$], q2[$];
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    addr_route_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .size_i(size),
        .priv_i(priv), .dat_remote_i(remote), .be_mode_i(be_mode),
        .port_rdy_i(rdy), .gnt_o(gnt), .err_o(err), .region_o(region),
        .prt_start_o(pstart), .prt_mst_o(pmst), .prt_bigend_o(pbig)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s cyc=%0d got=%0h exp=%0h", tag, what, cyc, got, exp);
        end
    endtask

    function automatic int exp_region(input int r, input logic [31:0] a);
        if (a <= 32'h1FFF_FFFF) begin
            if (r == 1) return (a <= 32'h1FFF_FFFC) ? 1 : 0;
            return 2;
        end
        if (a >= 32'hE004_0000 && a <= 32'hE00F_FFFF) return 4;
        if ((a >= 32'h2000_0000 && a <= 32'hDFFF_FFFF) || a >= 32'hE010_0000) return 3;
        return 0;
    endfunction

    function automatic bit exp_err(input int r, input txn_t t);
        int rg;
        rg = exp_region(r, t.a);
        if (rg == 0) return 1'b1;
        if (rg == 4) return (r == 1) || !t.pv || (t.sz != 2'd2) || (t.a[1:0] != 2'b00) || (r == 0 && t.rm);
        return 1'b0;
    endfunction

    task automatic push(input int r, input logic [31:0] a, input logic [1:0] sz, input logic pv, input logic rm);
        txn_t t;
        t.a = a; t.sz = sz; t.pv = pv; t.rm = rm;
        case (r)
            0: q0.push_back(t);
            1: q1.push_back(t);
            default: q2.push_back(t);
        endcase
    endtask

    function automatic int qsize(input int r);
        case (r)
            0: return q0.size();
            1: return q1.size();
            default: return q2.size();
        endcase
    endfunction

    // One cycle: drive at negedge, compare against the reference, advance the model.
    task automatic step();
        int  rg [3];
        bit  er [3];
        bit  g  [3];
        bit  st [4];
        int  ms [4];
        string tg;
        @(negedge clk);
        cyc++;
        for (int r = 0; r < 3; r++) begin
            if (!act[r] && qsize(r) > 0) begin
                case (r)
                    0: cur[r] = q0.pop_front();
                    1: cur[r] = q1.pop_front();
                    default: cur[r] = q2.pop_front();
                endcase
                act[r] = 1'b1;
            end
            req[r] = act[r];
            if (act[r]) begin
                addr[r] = cur[r].a; size[r] = cur[r].sz; priv[r] = cur[r].pv;
            end
        end
        remote = act[0] ? cur[0].rm : 1'b1;
        for (int p = 0; p < 4; p++) rdy[p] = (((cyc + p) % 3) == 0);
        #1;
        for (int r = 0; r < 3; r++) begin
            rg[r] = act[r] ? exp_region(r, cur[r].a) : 0;
            er[r] = act[r] ? exp_err(r, cur[r]) : 1'b0;
            g[r]  = 1'b0;
        end
        for (int p = 0; p < 4; p++) begin
            st[p] = 1'b0; ms[p] = 0;
            if (!busy_m[p]) begin
                for (int r = 0; r < 3; r++) begin
                    if (act[r] && !er[r] && rg[r] == p + 1 && !st[p]) begin
                        st[p] = 1'b1; ms[p] = r; g[r] = 1'b1;
                    end
                end
            end
        end
        for (int r = 0; r < 3; r++) begin
            if (act[r]) begin
                tg = (rg[r] == 1 || rg[r] == 2) ? "R1" : (rg[r] == 3) ? "R2" : "R3";
                chk(tg, "region", 32'(region[r]), 32'(rg[r]));
                tg = (rg[r] == 4 && r == 1) ? "R7" : (rg[r] == 4) ? "R6" : "R3";
                chk(tg, "err", 32'(err[r]), 32'(er[r]));
            end else begin
                chk("R3", "err_idle", 32'(err[r]), 32'd0);
            end
            chk("R4", "gnt", 32'(gnt[r]), 32'(g[r]));
            chk("R9", "gnt_and_err", 32'(gnt[r] & err[r]), 32'd0);
        end
        for (int p = 0; p < 4; p++) begin
            chk("R5", "port_start", 32'(pstart[p]), 32'(st[p]));
            if (st[p]) chk("R5", "port_master", 32'(pmst[p]), 32'(ms[p]));
        end
        chk("R8", "bigend", 32'(pbig), {28'd0, 1'b0, be_mode, be_mode, be_mode});
        for (int r = 0; r < 3; r++) if (g[r] || er[r]) act[r] = 1'b0;
        for (int p = 0; p < 4; p++) begin
            if (st[p]) busy_m[p] = 1'b1;
            else if (rdy[p]) busy_m[p] = 1'b0;
        end
    endtask

    task automatic run_idle();
        while (q0.size() > 0 || q1.size() > 0 || q2.size() > 0 || act[0] || act[1] || act[2]) step();
        repeat (4) step();
    endtask

    function automatic logic [31:0] pick_base(input logic [2:0] k);
        case (k)
            3'd0: return 32'h0000_1000;
            3'd1: return 32'h1FFF_FFF8;
            3'd2: return 32'h2000_0000;
            3'd3: return 32'h8000_0000;
            3'd4: return 32'hE000_0100;
            3'd5: return 32'hE004_0000;
            3'd6: return 32'hE00F_FFF0;
            default: return 32'hE010_0000;
        endcase
    endfunction

    initial begin
        for (int p = 0; p < 4; p++) busy_m[p] = 1'b0;
        for (int r = 0; r < 3; r++) act[r] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: after reset every port is free and nothing is answered.
        #1;
        chk("R10", "gnt_after_reset", 32'(gnt), 32'd0);
        chk("R10", "start_after_reset", 32'(pstart), 32'd0);
        chk("R10", "err_after_reset", 32'(err), 32'd0);
        // R10: first request after reset granted in the cycle it is presented.
        push(0, 32'h2000_0010, 2'd2, 1'b1, 1'b0);
        run_idle();
        // R4: three-way contention on the system port.
        push(0, 32'h2000_0000, 2'd2, 1'b1, 1'b0);
        push(1, 32'h3000_0000, 2'd2, 1'b1, 1'b0);
        push(2, 32'h4000_0000, 2'd2, 1'b1, 1'b0);
        run_idle();
        // R1: code ports; data beats debug on the code-data port.
        push(1, 32'h0000_0100, 2'd2, 1'b0, 1'b0);
        push(0, 32'h0000_0200, 2'd1, 1'b0, 1'b0);
        push(2, 32'h1FFF_FFFF, 2'd0, 1'b1, 1'b0);
        push(1, 32'h1FFF_FFFC, 2'd2, 1'b1, 1'b0);
        push(1, 32'h1FFF_FFFE, 2'd2, 1'b1, 1'b0);
        push(0, 32'h1FFF_FFFF, 2'd0, 1'b1, 1'b0);
        run_idle();
        // R2/R3: boundaries of the system and unrouted areas.
        push(0, 32'hDFFF_FFFF, 2'd0, 1'b1, 1'b0);
        push(0, 32'hE000_0000, 2'd2, 1'b1, 1'b0);
        push(0, 32'hE003_FFFC, 2'd2, 1'b1, 1'b0);
        push(2, 32'hE010_0000, 2'd2, 1'b1, 1'b0);
        push(2, 32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0);
        push(1, 32'hE010_0000, 2'd2, 1'b1, 1'b0);
        push(1, 32'h2000_0000, 2'd2, 1'b1, 1'b0);
        run_idle();
        // R5/R6: legal data and debug on the peripheral window; debug waits.
        push(0, 32'hE004_0000, 2'd2, 1'b1, 1'b0);
        push(2, 32'hE004_0004, 2'd2, 1'b1, 1'b0);
        push(0, 32'hE00F_FFFC, 2'd2, 1'b1, 1'b0);
        run_idle();
        // R6/R7: each rule violation on its own.
        push(0, 32'hE004_0010, 2'd2, 1'b0, 1'b0);
        push(0, 32'hE004_0010, 2'd1, 1'b1, 1'b0);
        push(0, 32'hE004_0012, 2'd2, 1'b1, 1'b0);
        push(0, 32'hE004_0010, 2'd2, 1'b1, 1'b1);
        push(1, 32'hE005_0000, 2'd2, 1'b1, 1'b0);
        push(2, 32'hE004_0020, 2'd0, 1'b1, 1'b0);
        push(2, 32'hE004_0024, 2'd2, 1'b1, 1'b1);
        run_idle();
        // R8: big-endian mode; the peripheral port stays little-endian.
        be_mode = 1'b1;
        push(0, 32'h2000_0100, 2'd2, 1'b1, 1'b0);
        push(2, 32'hE004_0100, 2'd2, 1'b1, 1'b0);
        push(1, 32'h0000_0040, 2'd2, 1'b1, 1'b0);
        run_idle();
        be_mode = 1'b0;
        // Mixed stream for all requirements.
        for (int n = 0; n < 400; n++) begin
            for (int r = 0; r < 3; r++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                push(r, pick_base(lf[2:0]) + {28'd0, lf[6:3]}, lf[8:7],
                     lf[9] | lf[10], lf[11] & lf[12]);
            end
            if (n % 50 == 0) be_mode = ~be_mode;
        end
        run_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired cyc=%0d got=1 exp=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule